// File: doc/BRIEF.md
# MRU Shift-In Translation Cache

This block keeps a handful of recently used virtual-to-physical page translations so that a core can skip a full translation for pages it touched a moment ago. Two independent stores are kept: one for instruction fetches and one for data accesses. Each store has its own depth. Pages are 4 KiB. A translation is learned through the insert port. The new entry always lands at the front of the chosen store, every older entry slides back by one position, and the entry at the back is lost.

The lookup port takes a virtual address, a store select and a read/write flag. All slots of the chosen store are compared in parallel. The response is registered and appears one cycle later. It carries the page-aligned physical address and the permission code of the frontmost matching entry. A bypass input stops learning, and a flush input forgets everything.

Top module: `xlat_mru_cache`

## Requirements
- R1: After reset every slot is invalid. `rsp_valid`, `rsp_hit`, `rsp_paddr` and `rsp_perm` are 0, and every lookup misses until an insert is made.
- R2: The page number is the virtual address shifted right by 12. The stored physical address has its low 12 bits cleared, so a hit returns `rsp_paddr` with bits [11:0] equal to 0 and upper bits equal to the inserted physical page.
- R3: An accepted insert places the new entry in slot 0 and moves slots 0..N-2 into slots 1..N-1. After N further inserts into the same store, the entry that was in slot 0 is gone.
- R4: An insert with `ins_write`=0 stores permission code 1. An insert with `ins_write`=1 stores code 2. A hit reports the stored code on `rsp_perm`.
- R5: `ins_code`=1 / `lk_code`=1 selects the instruction store and 0 selects the data store. An entry inserted into one store is never seen by lookups of the other store.
- R6: While `bypass` is 1, inserts are ignored and leave both stores unchanged.
- R7: When several valid slots match, the lookup uses the lowest-numbered one, which is the most recently inserted.
- R8: A write lookup (`lk_write`=1) hits only if the selected matching entry has permission code 2. A read lookup hits on either code.
- R9: `flush` clears every valid bit in both stores. An insert in the same cycle as a flush is dropped.
- R10: The response to a lookup appears one cycle later, with `rsp_valid` equal to the previous cycle's `lk_valid`. A lookup sees the store contents from before any insert or flush in its own cycle.
- R11: On a miss, or when no lookup was made, `rsp_paddr` and `rsp_perm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries in both stores |
| bypass | input | 1 | Ignore inserts while high |
| ins_valid | input | 1 | Insert request |
| ins_code | input | 1 | Insert into instruction store (1) or data store (0) |
| ins_write | input | 1 | Translation learned by a write (perm 2) or read (perm 1) |
| ins_vaddr | input | VA_W | Virtual address of the new translation |
| ins_paddr | input | PA_W | Physical address of the new translation |
| lk_valid | input | 1 | Lookup request |
| lk_code | input | 1 | Look up the instruction store (1) or data store (0) |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Response present for last cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | PA_W | Page-aligned physical address on hit, else 0 |
| rsp_perm | output | 2 | Permission code on hit, else 0 |

## Verification
Every lookup result is due on the clock edge after the lookup is presented. An insert or flush changes only lookups presented on a later cycle. The bench applies one cycle of stimulus just after a falling edge and takes the expected result from its model, using the model's state before that cycle's update. It then lets the rising edge pass, updates the model, and compares all four response outputs at the next falling edge. A lookup and an insert in the same cycle therefore check that the older contents are used. The checker confirms the one-cycle response relation and the post-flush miss on the live ports.

// File: rtl/xlat_mru_cache.sv
module xlat_mru_cache #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int I_DEPTH = 4,
  parameter int D_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            bypass,
  input  logic            ins_valid,
  input  logic            ins_code,
  input  logic            ins_write,
  input  logic [VA_W-1:0] ins_vaddr,
  input  logic [PA_W-1:0] ins_paddr,
  input  logic            lk_valid,
  input  logic            lk_code,
  input  logic            lk_write,
  input  logic [VA_W-1:0] lk_vaddr,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_perm
);
  localparam int PG    = 12;
  localparam int VPN_W = VA_W - PG;
  localparam int PPN_W = PA_W - PG;

  logic [VPN_W-1:0] i_vpn [I_DEPTH];
  logic [PPN_W-1:0] i_ppn [I_DEPTH];
  logic [1:0]       i_perm[I_DEPTH];
  logic [I_DEPTH-1:0] i_vld;
  logic [VPN_W-1:0] d_vpn [D_DEPTH];
  logic [PPN_W-1:0] d_ppn [D_DEPTH];
  logic [1:0]       d_perm[D_DEPTH];
  logic [D_DEPTH-1:0] d_vld;

  wire [VPN_W-1:0] new_vpn  = ins_vaddr[VA_W-1:PG];
  wire [PPN_W-1:0] new_ppn  = ins_paddr[PA_W-1:PG];
  wire [1:0]       new_perm = ins_write ? 2'd2 : 2'd1;
  wire             take     = ins_valid && !bypass && !flush;
  wire             take_i   = take && ins_code;
  wire             take_d   = take && !ins_code;
  wire [VPN_W-1:0] lk_vpn   = lk_vaddr[VA_W-1:PG];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) i_vld <= '0;
    else if (take_i)     i_vld <= {i_vld[I_DEPTH-2:0], 1'b1};
    if (!rst_n || flush) d_vld <= '0;
    else if (take_d)     d_vld <= {d_vld[D_DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk) begin
    if (take_i) begin
      for (int k = I_DEPTH-1; k > 0; k--) begin
        i_vpn[k]  <= i_vpn[k-1];
        i_ppn[k]  <= i_ppn[k-1];
        i_perm[k] <= i_perm[k-1];
      end
      i_vpn[0]  <= new_vpn;
      i_ppn[0]  <= new_ppn;
      i_perm[0] <= new_perm;
    end
    if (take_d) begin
      for (int k = D_DEPTH-1; k > 0; k--) begin
        d_vpn[k]  <= d_vpn[k-1];
        d_ppn[k]  <= d_ppn[k-1];
        d_perm[k] <= d_perm[k-1];
      end
      d_vpn[0]  <= new_vpn;
      d_ppn[0]  <= new_ppn;
      d_perm[0] <= new_perm;
    end
  end

  logic             i_hit, d_hit;
  logic [PPN_W-1:0] i_sel_ppn, d_sel_ppn;
  logic [1:0]       i_sel_perm, d_sel_perm;

  always_comb begin
    i_hit = 1'b0; i_sel_ppn = '0; i_sel_perm = '0;
    for (int k = I_DEPTH-1; k >= 0; k--)
      if (i_vld[k] && i_vpn[k] == lk_vpn) begin
        i_hit = 1'b1; i_sel_ppn = i_ppn[k]; i_sel_perm = i_perm[k];
      end
    d_hit = 1'b0; d_sel_ppn = '0; d_sel_perm = '0;
    for (int k = D_DEPTH-1; k >= 0; k--)
      if (d_vld[k] && d_vpn[k] == lk_vpn) begin
        d_hit = 1'b1; d_sel_ppn = d_ppn[k]; d_sel_perm = d_perm[k];
      end
  end

  wire             sel_hit  = lk_code ? i_hit : d_hit;
  wire [PPN_W-1:0] sel_ppn  = lk_code ? i_sel_ppn : d_sel_ppn;
  wire [1:0]       sel_perm = lk_code ? i_sel_perm : d_sel_perm;
  wire             hit_now  = lk_valid && sel_hit && (!lk_write || sel_perm == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= hit_now;
      rsp_paddr <= hit_now ? {sel_ppn, {PG{1'b0}}} : '0;
      rsp_perm  <= hit_now ? sel_perm : 2'd0;
    end
  end
endmodule

// File: rtl/xlat_mru_cache_chk.sv
module xlat_mru_cache_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            lk_valid,
  input logic            lk_write,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_perm
);
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(lk_valid));
  p_hit_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  p_page_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_paddr[11:0] == 12'd0);
  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_paddr == '0 && rsp_perm == 2'd0));
  p_perm_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_perm == 2'd1 || rsp_perm == 2'd2));
  p_write_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_write |=> (!rsp_hit || rsp_perm == 2'd2));
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 lk_valid |=> !rsp_hit);
endmodule

bind xlat_mru_cache xlat_mru_cache_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
  .lk_write(lk_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm)
);

// File: tb/tb_xlat_mru_cache.sv
`timescale 1ns/1ps
module tb_xlat_mru_cache;
  localparam int ID = 4, DD = 8;
  logic clk = 0, rst_n = 0, flush = 0, bypass = 0;
  logic ins_valid = 0, ins_code = 0, ins_write = 0;
  logic [31:0] ins_vaddr = 0, ins_paddr = 0, lk_vaddr = 0;
  logic lk_valid = 0, lk_code = 0, lk_write = 0;
  logic rsp_valid, rsp_hit;
  logic [31:0] rsp_paddr;
  logic [1:0] rsp_perm;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xlat_mru_cache #(.VA_W(32), .PA_W(32), .I_DEPTH(ID), .D_DEPTH(DD)) dut (.*);

  logic [19:0] m_vpn [2][8];
  logic [19:0] m_ppn [2][8];
  logic [1:0]  m_perm[2][8];
  bit          m_vld [2][8];

  function automatic int depth(int b); return b ? ID : DD; endfunction

  task automatic mlook(input int b, input logic [19:0] v, input bit w,
                       output bit h, output logic [19:0] p, output logic [1:0] pm);
    h = 0; p = 0; pm = 0;
    for (int k = 0; k < depth(b); k++)
      if (m_vld[b][k] && m_vpn[b][k] == v) begin
        if (!w || m_perm[b][k] == 2'd2) begin h = 1; p = m_ppn[b][k]; pm = m_perm[b][k]; end
        break;
      end
  endtask

  task automatic mclear();
    for (int b = 0; b < 2; b++) for (int k = 0; k < 8; k++) m_vld[b][k] = 0;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit lv, lc, lw, input logic [31:0] la,
                      input bit iv, ic, iw, input logic [31:0] ia, ip,
                      input bit byp, fl, input string tag);
    bit eh; logic [19:0] ep; logic [1:0] epm; int b;
    lk_valid = lv; lk_code = lc; lk_write = lw; lk_vaddr = la;
    ins_valid = iv; ins_code = ic; ins_write = iw; ins_vaddr = ia; ins_paddr = ip;
    bypass = byp; flush = fl;
    mlook(lc ? 1 : 0, la[31:12], lw, eh, ep, epm);
    if (!lv) begin eh = 0; ep = 0; epm = 0; end
    @(posedge clk);
    if (fl) mclear();
    else if (iv && !byp) begin
      b = ic ? 1 : 0;
      for (int k = depth(b)-1; k > 0; k--) begin
        m_vpn[b][k] = m_vpn[b][k-1]; m_ppn[b][k] = m_ppn[b][k-1];
        m_perm[b][k] = m_perm[b][k-1]; m_vld[b][k] = m_vld[b][k-1];
      end
      m_vpn[b][0] = ia[31:12]; m_ppn[b][0] = ip[31:12];
      m_perm[b][0] = iw ? 2'd2 : 2'd1; m_vld[b][0] = 1;
    end
    @(negedge clk);
    chk({tag, " R10 valid"}, rsp_valid, lv);
    chk({tag, " hit"}, rsp_hit, eh);
    chk({tag, " R11 paddr"}, rsp_paddr, {ep, 12'h000});
    chk({tag, " perm"}, rsp_perm, epm);
  endtask

  task automatic look(bit c, bit w, logic [31:0] a, string tag);
    step(1, c, w, a, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic put(bit c, bit w, logic [31:0] a, logic [31:0] p, string tag);
    step(0, 0, 0, 0, 1, c, w, a, p, 0, 0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mclear();
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 rsp_hit", rsp_hit, 0);
    chk("R1 rsp_paddr", rsp_paddr, 0);
    rst_n = 1;
    look(1, 0, 32'h1234_5000, "R1 empty");
    look(0, 0, 32'h0000_0000, "R1 empty data");

    put(1, 0, 32'h1234_5678, 32'hABCD_E123, "R2 put");
    look(1, 0, 32'h1234_5FFF, "R2 R4 read hit");
    chk("R2 explicit paddr", rsp_paddr, 32'hABCD_E000);
    chk("R4 explicit perm", rsp_perm, 2'd1);
    look(0, 0, 32'h1234_5678, "R5 other store");
    chk("R5 explicit miss", rsp_hit, 0);
    look(1, 1, 32'h1234_5678, "R8 write on ro");
    chk("R8 explicit miss", rsp_hit, 0);

    put(0, 1, 32'h0000_3000, 32'h7777_7000, "R4 write put");
    look(0, 1, 32'h0000_3ABC, "R4 R8 write hit");
    chk("R8 explicit hit", rsp_perm, 2'd2);

    step(0, 0, 0, 0, 1, 0, 0, 32'h0000_9000, 32'h5555_5000, 1, 0, "R6 bypass");
    look(0, 0, 32'h0000_9000, "R6 bypassed miss");
    chk("R6 explicit miss", rsp_hit, 0);

    put(0, 0, 32'h0000_3000, 32'h1111_1000, "R7 dup");
    look(0, 0, 32'h0000_3000, "R7 newest");
    chk("R7 explicit paddr", rsp_paddr, 32'h1111_1000);
    look(0, 1, 32'h0000_3000, "R7 R8 front ro");

    for (int n = 0; n < ID; n++) put(1, 0, 32'h4000_0000 + (n << 12), 32'h2000_0000 + (n << 12), "R3 fill");
    look(1, 0, 32'h1234_5000, "R3 evicted");
    chk("R3 explicit evicted", rsp_hit, 0);
    look(1, 0, 32'h4000_0000, "R3 oldest kept");
    chk("R3 explicit kept", rsp_hit, 1);

    step(1, 0, 0, 32'h0000_A000, 1, 0, 0, 32'h0000_A000, 32'h3333_3000, 0, 0, "R10 same cycle");
    chk("R10 explicit old view", rsp_hit, 0);
    look(0, 0, 32'h0000_A000, "R10 after");

    step(1, 0, 0, 32'h0000_A000, 1, 1, 0, 32'h0000_B000, 32'h4444_4000, 0, 1, "R9 flush");
    chk("R9 pre-flush view", rsp_hit, 1);
    look(0, 0, 32'h0000_A000, "R9 flushed data");
    look(1, 0, 32'h0000_B000, "R9 dropped insert");
    chk("R9 explicit miss", rsp_hit, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] va, vb, pa;
      va = {28'h0, 4'($urandom)} << 12 | 32'($urandom % 4096);
      vb = {28'h0, 4'($urandom)} << 12;
      pa = $urandom;
      step($urandom % 2, $urandom % 2, $urandom % 2, va,
           ($urandom % 3) != 0, $urandom % 2, $urandom % 2, vb, pa,
           ($urandom % 8) == 0, ($urandom % 64) == 0, "R3 R7 R8 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule